// File: doc/BRIEF.md
# UART Internal Loopback and Modem-Control Mapper

This block sits between a UART's register file, its receive FIFO and its line-side pins, and implements the internal self-test path. A single mode bit in the control register selects between normal operation and loopback. In normal operation, transmit writes go to the line-side transmit output. Characters from the external receiver are pushed into the receive FIFO. The four modem-status flags track the external modem input pins.

In loopback every transmitted character is pushed into the receive FIFO and does not go to the line. External received characters are thrown away. A rising edge of the send-break control bit pushes a break-tagged word into the receive path. The four software modem-control outputs are fed back crosswise onto the modem-status flags, and the modem-status raw interrupt bits are rebuilt from them.

The sequencing is a three-state machine. The states are `LB_NORMAL` (loopback off), `LB_LOOP` (loopback on, nothing pending) and `LB_LOOP_BRK` (loopback on, a break word waiting for a free push slot). The transitions are:
- NORMAL→LOOP on a control write with the mode bit set.
- LOOP→NORMAL and LOOP_BRK→NORMAL on a control write with the mode bit clear.
- LOOP→LOOP_BRK when a break edge meets a transmit write in the same cycle.
- LOOP_BRK→LOOP on the first cycle without a transmit write, which is when the break word is issued.

Top module: `uart_loopback`

## Requirements
- R1: After reset all outputs are 0: no push, push word 0, no transmit output, transmit data 0, modem flags 0, modem interrupt bits 0, and the block is in normal mode.
- R2: A control write with `ctrl_lbe`=1 loads the modem flags at the next clock edge. The flags are bit 3 ring-indicate ← `ctrl_out2`, bit 2 carrier-detect ← `ctrl_out1`, bit 1 clear-to-send ← `ctrl_rts`, bit 0 data-set-ready ← `ctrl_dtr`. While in loopback without such a write, the flags hold.
- R3: The mapping of R2 is applied by every control write with `ctrl_lbe`=1, including the write that first turns loopback on.
- R4: On a control write with `ctrl_lbe`=1, all four modem interrupt bits are first cleared. Each bit is then set where the newly mapped flag at the same position is 1.
- R5: In loopback, a transmit write pushes the word {zeros, `tx_data`} into the receive FIFO one cycle later and produces no transmit output. The mode that applies is the one in force before any control write in the same cycle.
- R6: In loopback, `ext_rx_valid` produces no push.
- R7: In loopback, a 0→1 change of `brk_ctrl` pushes a word with only bit WORD_W-1 (bit 10 by default) set. A level that stays high pushes nothing further.
- R8: If a break edge and a transmit write fall in the same cycle, the transmit word is pushed first. The break word is pushed in the next cycle without a transmit write.
- R9: In normal mode, and on a control write with `ctrl_lbe`=0, the modem flags take the value of `ext_modem` one cycle later. Such writes never change the modem interrupt bits.
- R10: In normal mode, a transmit write produces `tx_out_valid` with `tx_out_data` one cycle later, and `ext_rx_valid` pushes {zeros, `ext_rx_data`}.
- R11: A push is dropped, with `fifo_push` low in the next cycle, when `fifo_ready` is 0 in the cycle the push is requested. A deferred break is discarded either way.
- R12: A control write with `ctrl_lbe`=0 discards a break that is still waiting. A break edge seen in normal mode pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_lbe | input | 1 | Written loopback-mode bit |
| ctrl_rts | input | 1 | Written request-to-send output |
| ctrl_dtr | input | 1 | Written data-terminal-ready output |
| ctrl_out1 | input | 1 | Written user output 1 |
| ctrl_out2 | input | 1 | Written user output 2 |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmit character |
| brk_ctrl | input | 1 | Send-break control level |
| ext_rx_valid | input | 1 | External receiver character valid |
| ext_rx_data | input | DATA_W | External receiver character |
| ext_modem | input | 4 | External modem pins {RI, DCD, CTS, DSR} |
| fifo_ready | input | 1 | Receive FIFO can accept a word |
| fifo_push | output | 1 | Push strobe to receive FIFO |
| fifo_word | output | WORD_W | Word to push (top bit = break tag) |
| tx_out_valid | output | 1 | Character to line-side transmitter |
| tx_out_data | output | DATA_W | Line-side transmit character |
| ms_flags | output | 4 | Modem status flags {RI, DCD, CTS, DSR} |
| ms_irq | output | 4 | Modem raw interrupt bits {RI, DCD, CTS, DSR} |

## Verification
The bench targets three collision cases:
- A break edge that meets a transmit write. A design without the deferred state would lose the break or overwrite the character.
- Disabling loopback while a break is deferred. A wrong design would leak a stray break word into normal mode.
- A control write in the same cycle as traffic. A design that used the new mode at once would misroute that character.

It also checks that a second loopback write clears interrupt bits whose flags dropped. A design that only ORed the new flags in would leave stale bits set. Writes with the mode bit clear must leave the flags on the external pins and the interrupt bits untouched. Dropped pushes under backpressure are checked as well.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    // Mode sequencer states
    typedef enum logic [1:0] {
        LB_NORMAL   = 2'd0,
        LB_LOOP     = 2'd1,
        LB_LOOP_BRK = 2'd2
    } lb_state_e;

    // Source selected for the receive-FIFO push this cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TX   = 2'd1,
        SRC_BRK  = 2'd2,
        SRC_EXT  = 2'd3
    } push_src_e;

    // Modem flag / interrupt bit positions
    localparam int MS_W   = 4;
    localparam int MS_RI  = 3;
    localparam int MS_DCD = 2;
    localparam int MS_CTS = 1;
    localparam int MS_DSR = 0;

endpackage

// File: rtl/uart_lb_fsm.sv
module uart_lb_fsm
    import uart_lb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      ctrl_lbe,
    input  logic      tx_wr,
    input  logic      brk_ctrl,
    input  logic      ext_rx_valid,
    output logic      loop_on,
    output push_src_e push_src
);

    lb_state_e state_q, state_d;
    logic      brk_q;
    logic      brk_edge;
    logic      dis_wr;
    logic      en_wr;

    assign en_wr    = ctrl_wr & ctrl_lbe;
    assign dis_wr   = ctrl_wr & ~ctrl_lbe;
    assign brk_edge = brk_ctrl & ~brk_q & (state_q != LB_NORMAL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LB_NORMAL;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            brk_q   <= brk_ctrl;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LB_NORMAL: begin
                if (en_wr) state_d = LB_LOOP;
            end
            LB_LOOP: begin
                if (dis_wr)                state_d = LB_NORMAL;
                else if (brk_edge && tx_wr) state_d = LB_LOOP_BRK;
            end
            LB_LOOP_BRK: begin
                if (dis_wr)      state_d = LB_NORMAL;
                else if (!tx_wr) state_d = LB_LOOP;
            end
            default: state_d = LB_NORMAL;
        endcase
    end

    // Outputs
    always_comb begin
        push_src = SRC_NONE;
        unique case (state_q)
            LB_NORMAL:   push_src = ext_rx_valid ? SRC_EXT : SRC_NONE;
            LB_LOOP:     push_src = tx_wr ? SRC_TX : (brk_edge ? SRC_BRK : SRC_NONE);
            LB_LOOP_BRK: push_src = tx_wr ? SRC_TX : SRC_BRK;
            default:     push_src = SRC_NONE;
        endcase
    end

    assign loop_on = (state_q != LB_NORMAL);

    // R6
    no_ext_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> (push_src != SRC_EXT));

endmodule

// File: rtl/uart_lb_modem.sv
module uart_lb_modem
    import uart_lb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            ctrl_lbe,
    input  logic            ctrl_rts,
    input  logic            ctrl_dtr,
    input  logic            ctrl_out1,
    input  logic            ctrl_out2,
    input  logic            loop_on,
    input  logic [MS_W-1:0] ext_modem,
    output logic [MS_W-1:0] ms_flags,
    output logic [MS_W-1:0] ms_irq
);

    logic [MS_W-1:0] mapped;
    logic [MS_W-1:0] irq_d;
    logic            map_wr;
    logic            follow_pins;

    always_comb begin
        mapped         = '0;
        mapped[MS_RI]  = ctrl_out2;
        mapped[MS_DCD] = ctrl_out1;
        mapped[MS_CTS] = ctrl_rts;
        mapped[MS_DSR] = ctrl_dtr;
    end

    assign map_wr      = ctrl_wr & ctrl_lbe;
    assign follow_pins = ctrl_wr ? ~ctrl_lbe : ~loop_on;

    // Clear every modem interrupt bit, then set those whose flag is high
    always_comb begin
        irq_d = ms_irq;
        for (int i = 0; i < MS_W; i++) begin
            irq_d[i] = 1'b0;
            if (mapped[i]) irq_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_flags <= '0;
            ms_irq   <= '0;
        end else if (map_wr) begin
            ms_flags <= mapped;
            ms_irq   <= irq_d;
        end else if (follow_pins) begin
            ms_flags <= ext_modem;
        end
    end

    // R2
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_lbe) |=>
            ms_flags == {$past(ctrl_out2), $past(ctrl_out1), $past(ctrl_rts), $past(ctrl_dtr)});

    // R4
    irq_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_lbe) |=> ms_irq == ms_flags);

    // R9
    pins_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr ? !ctrl_lbe : !loop_on) |=> ms_flags == $past(ext_modem));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && ctrl_lbe) |=> $stable(ms_irq));

endmodule

// File: rtl/uart_lb_datapath.sv
module uart_lb_datapath
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  push_src_e         push_src,
    input  logic              fifo_ready,
    input  logic              loop_on,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [DATA_W-1:0] ext_rx_data,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_word,
    output logic              tx_out_valid,
    output logic [DATA_W-1:0] tx_out_data
);

    localparam int BRK_POS = WORD_W - 1;
    localparam int PAD_W   = WORD_W - DATA_W;

    logic [WORD_W-1:0] word_c;
    logic              push_c;
    logic              tx_line;

    always_comb begin
        word_c = '0;
        unique case (push_src)
            SRC_TX:  word_c = {{PAD_W{1'b0}}, tx_data};
            SRC_EXT: word_c = {{PAD_W{1'b0}}, ext_rx_data};
            SRC_BRK: word_c[BRK_POS] = 1'b1;
            default: word_c = '0;
        endcase
    end

    assign push_c  = (push_src != SRC_NONE) & fifo_ready;
    assign tx_line = tx_wr & ~loop_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_push    <= 1'b0;
            fifo_word    <= '0;
            tx_out_valid <= 1'b0;
            tx_out_data  <= '0;
        end else begin
            fifo_push    <= push_c;
            tx_out_valid <= tx_line;
            if (push_c)  fifo_word   <= word_c;
            if (tx_line) tx_out_data <= tx_data;
        end
    end

    // R11
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_ready |=> !fifo_push);

    // R5
    loop_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_on && tx_wr && fifo_ready) |=>
            (fifo_push && fifo_word == {{PAD_W{1'b0}}, $past(tx_data)} && !tx_out_valid));

    // R10
    line_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_on && tx_wr) |=> (tx_out_valid && tx_out_data == $past(tx_data)));

endmodule

// File: rtl/uart_loopback.sv
module uart_loopback
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_lbe,
    input  logic              ctrl_rts,
    input  logic              ctrl_dtr,
    input  logic              ctrl_out1,
    input  logic              ctrl_out2,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              brk_ctrl,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic [3:0]        ext_modem,
    input  logic              fifo_ready,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_word,
    output logic              tx_out_valid,
    output logic [DATA_W-1:0] tx_out_data,
    output logic [3:0]        ms_flags,
    output logic [3:0]        ms_irq
);

    logic      loop_on;
    push_src_e push_src;

    uart_lb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_lbe     (ctrl_lbe),
        .tx_wr        (tx_wr),
        .brk_ctrl     (brk_ctrl),
        .ext_rx_valid (ext_rx_valid),
        .loop_on      (loop_on),
        .push_src     (push_src)
    );

    uart_lb_modem u_modem (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_lbe  (ctrl_lbe),
        .ctrl_rts  (ctrl_rts),
        .ctrl_dtr  (ctrl_dtr),
        .ctrl_out1 (ctrl_out1),
        .ctrl_out2 (ctrl_out2),
        .loop_on   (loop_on),
        .ext_modem (ext_modem),
        .ms_flags  (ms_flags),
        .ms_irq    (ms_irq)
    );

    uart_lb_datapath #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_src     (push_src),
        .fifo_ready   (fifo_ready),
        .loop_on      (loop_on),
        .tx_wr        (tx_wr),
        .tx_data      (tx_data),
        .ext_rx_data  (ext_rx_data),
        .fifo_push    (fifo_push),
        .fifo_word    (fifo_word),
        .tx_out_valid (tx_out_valid),
        .tx_out_data  (tx_out_data)
    );

    initial begin
        // R7
        word_width_chk: assert (WORD_W > DATA_W);
    end

endmodule

// File: tb/uart_loopback_tb.sv
`timescale 1ns/1ps
module uart_loopback_tb;

    localparam int DATA_W = 8;
    localparam int WORD_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 0, ctrl_lbe = 0, ctrl_rts = 0, ctrl_dtr = 0, ctrl_out1 = 0, ctrl_out2 = 0;
    logic tx_wr = 0;
    logic [DATA_W-1:0] tx_data = '0;
    logic brk_ctrl = 0;
    logic ext_rx_valid = 0;
    logic [DATA_W-1:0] ext_rx_data = '0;
    logic [3:0] ext_modem = '0;
    logic fifo_ready = 1'b1;
    logic fifo_push;
    logic [WORD_W-1:0] fifo_word;
    logic tx_out_valid;
    logic [DATA_W-1:0] tx_out_data;
    logic [3:0] ms_flags, ms_irq;

    always #2.5 clk = ~clk;

    uart_loopback #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_lbe(ctrl_lbe),
        .ctrl_rts(ctrl_rts), .ctrl_dtr(ctrl_dtr), .ctrl_out1(ctrl_out1),
        .ctrl_out2(ctrl_out2), .tx_wr(tx_wr), .tx_data(tx_data),
        .brk_ctrl(brk_ctrl), .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data),
        .ext_modem(ext_modem), .fifo_ready(fifo_ready), .fifo_push(fifo_push),
        .fifo_word(fifo_word), .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .ms_flags(ms_flags), .ms_irq(ms_irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit m_loop, m_pend, m_brk_prev, m_push, m_txv;
    int m_word, m_txd, m_flags, m_irq;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_loop = 0; m_pend = 0; m_brk_prev = 0; m_push = 0; m_txv = 0;
        m_word = 0; m_txd = 0; m_flags = 0; m_irq = 0;
    endtask

    // Advance the model using the inputs seen at the clock edge just taken
    task automatic model_step();
        bit brk_edge, want;
        int w;
        brk_edge = brk_ctrl && !m_brk_prev && m_loop;
        want = 0; w = 0;
        if (!m_loop) begin
            if (ext_rx_valid) begin want = 1; w = ext_rx_data; end
        end else if (tx_wr) begin
            want = 1; w = tx_data;
        end else if (m_pend || brk_edge) begin
            want = 1; w = 1 << (WORD_W - 1);
        end
        m_push = want && fifo_ready;
        if (m_push) m_word = w;
        if (!m_loop) m_pend = 0;
        else if (tx_wr) m_pend = m_pend || brk_edge;
        else m_pend = 0;
        if (ctrl_wr && !ctrl_lbe) m_pend = 0;
        m_txv = tx_wr && !m_loop;
        if (m_txv) m_txd = tx_data;
        if (ctrl_wr && ctrl_lbe) begin
            m_flags = {ctrl_out2, ctrl_out1, ctrl_rts, ctrl_dtr};
            m_irq = m_flags;
        end else if (ctrl_wr ? !ctrl_lbe : !m_loop) begin
            m_flags = ext_modem;
        end
        if (ctrl_wr) m_loop = ctrl_lbe;
        m_brk_prev = brk_ctrl;
    endtask

    task automatic compare();
        chk(cur_req, "fifo_push", fifo_push, m_push);
        chk(cur_req, "fifo_word", fifo_word, m_word);
        chk(cur_req, "tx_out_valid", tx_out_valid, m_txv);
        chk(cur_req, "tx_out_data", tx_out_data, m_txd);
        chk(cur_req, "ms_flags", ms_flags, m_flags);
        chk(cur_req, "ms_irq", ms_irq, m_irq);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (rst_n) model_step(); else model_reset();
        compare();
    endtask

    task automatic idle();
        ctrl_wr = 0; tx_wr = 0; ext_rx_valid = 0;
    endtask

    task automatic wr_ctrl(input bit lbe, input bit o2, input bit o1, input bit rts, input bit dtr);
        ctrl_wr = 1; ctrl_lbe = lbe; ctrl_out2 = o2; ctrl_out1 = o1; ctrl_rts = rts; ctrl_dtr = dtr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        tick(); tick();
        // R1: explicit reset state
        chk("R1", "push_in_reset", fifo_push, 0);
        chk("R1", "flags_in_reset", ms_flags, 0);
        chk("R1", "irq_in_reset", ms_irq, 0);
        rst_n = 1;
        tick();

        // R10: normal mode traffic
        cur_req = "R10";
        ext_modem = 4'b0101;
        tx_wr = 1; tx_data = 8'h5A; ext_rx_valid = 1; ext_rx_data = 8'h33;
        tick();
        chk("R10", "line_tx", tx_out_data, 8'h5A);
        chk("R10", "ext_push", fifo_word, 8'h33);
        idle(); tick();

        // R9: write with loopback off leaves flags on pins, irq untouched
        cur_req = "R9";
        wr_ctrl(0, 1, 1, 1, 1);
        tick();
        chk("R9", "flags_pins", ms_flags, 4'b0101);
        idle(); ext_modem = 4'b1001; tick(); tick();
        chk("R9", "irq_untouched", ms_irq, 0);

        // R3 / R2: enabling write maps outputs at once
        cur_req = "R3";
        wr_ctrl(1, 1, 0, 1, 0);
        tick();
        chk("R2", "mapped_flags", ms_flags, 4'b1010);
        chk("R3", "enable_write_maps", ms_flags, 4'b1010);
        idle(); ext_modem = 4'b1111; tick();
        chk("R2", "flags_hold_in_loop", ms_flags, 4'b1010);

        // R4: second write clears stale interrupt bits
        cur_req = "R4";
        wr_ctrl(1, 0, 1, 1, 1);
        tick();
        chk("R4", "irq_rebuilt", ms_irq, 4'b0111);
        idle(); tick();

        // R5: transmit loops into FIFO
        cur_req = "R5";
        tx_wr = 1; tx_data = 8'hC3; tick();
        chk("R5", "loop_word", fifo_word, 8'hC3);
        chk("R5", "no_line_tx", tx_out_valid, 0);
        idle(); tick();

        // R6: external receive discarded
        cur_req = "R6";
        ext_rx_valid = 1; ext_rx_data = 8'h77; tick();
        chk("R6", "ext_dropped", fifo_push, 0);
        idle(); tick();

        // R7: break edge pushes tagged word once
        cur_req = "R7";
        brk_ctrl = 1; tick();
        chk("R7", "brk_word", fifo_word, 1 << (WORD_W - 1));
        tick(); tick();
        chk("R7", "level_no_push", fifo_push, 0);
        brk_ctrl = 0; tick();

        // R8: break collides with transmit
        cur_req = "R8";
        brk_ctrl = 1; tx_wr = 1; tx_data = 8'h11; tick();
        chk("R8", "tx_first", fifo_word, 8'h11);
        tx_data = 8'h22; tick();
        chk("R8", "tx_again", fifo_word, 8'h22);
        idle(); tick();
        chk("R8", "brk_after", fifo_word, 1 << (WORD_W - 1));
        brk_ctrl = 0; tick();

        // R11: backpressure drops push
        cur_req = "R11";
        fifo_ready = 0; tx_wr = 1; tx_data = 8'h44; tick();
        chk("R11", "dropped", fifo_push, 0);
        fifo_ready = 1; idle(); tick();

        // R12: disabling loopback discards deferred break
        cur_req = "R12";
        brk_ctrl = 1; tx_wr = 1; tx_data = 8'h66; tick();
        wr_ctrl(0, 0, 0, 0, 0); tx_data = 8'h67; tick();
        idle(); tick();
        chk("R12", "no_stray_brk", fifo_push, 0);
        brk_ctrl = 0; tick(); brk_ctrl = 1; tick(); tick();
        chk("R12", "normal_brk_ignored", fifo_push, 0);
        brk_ctrl = 0;

        // Mixed pseudo-random traffic against the model
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            ctrl_wr = ($urandom % 8) == 0;
            ctrl_lbe = ($urandom % 3) != 0;
            {ctrl_out2, ctrl_out1, ctrl_rts, ctrl_dtr} = 4'($urandom);
            tx_wr = $urandom % 2;
            tx_data = 8'($urandom);
            brk_ctrl = ($urandom % 4) == 0;
            ext_rx_valid = $urandom % 2;
            ext_rx_data = 8'($urandom);
            ext_modem = 4'($urandom);
            fifo_ready = ($urandom % 5) != 0;
            tick();
        end
        idle();
        tick();
        finish_run();
    end

endmodule